// File: doc/BRIEF.md
# Power-Up Serial EEPROM Configuration Loader

This block comes out of reset and fills its configuration outputs from a small serial EEPROM. No host takes part. It reads fourteen 16-bit words, at word addresses 0 through 13 in ascending order, over a four-wire serial link: select, clock, command/data out and data in. It keeps every raw word in a local buffer.

When the last word has arrived, it unpacks the words into fields for five logical devices. These are memory ranges, I/O bases, I/O block sizes, IRQ levels, DMA channels, active flags, two output-enable configurations, a mode bit and a five-entry DMA remapping table. The mode bit decides which of these fields take effect, and every field it excludes reads as zero. A done flag then rises, and the serial link stays idle until the next reset.

The serial clock runs at the system clock divided by `2*SK_DIV`. Each read frame holds the 3-bit opcode `110`, then a 6-bit address, then one dummy bit, then 16 data bits with the MSB first.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While reset is held and right after it, `ee_cs`, `ee_sk`, `ee_di` and `cfg_done` are 0 and every configuration output is 0.
- R2: Each frame shifts out on `ee_di` nine command bits, MSB first: opcode bits `110`, then the 6-bit word address. Frames cover addresses 0 to 13 in ascending order, exactly once each.
- R3: After the command, the block sends one dummy bit and keeps `ee_di` low. It then captures 16 data bits MSB first from `ee_do` on rising `ee_sk`. A frame therefore has exactly 26 rising `ee_sk` edges.
- R4: `ee_sk` is only high while `ee_cs` is high, and `ee_cs` falls between consecutive words.
- R5: One `ee_sk` period equals `2*SK_DIV` system clock cycles.
- R6: Field layout. Let word k be Wk.
  - `mem_base0/1` come from W0/W1 and `mem_top0/1` from W2/W3. Each holds bits 23..8 of the address.
  - `io_base[16d+:16]` comes from W(4+d).
  - `io_size[3d+:3]` comes from W9 bits [15-3d -: 3].
  - `irq_lvl[4d+:4]` for d=0..3 comes from W10 bits [15-4d -: 4]; for d=4 it comes from W11[15:12].
  - `dma_chan[2:0]` comes from W11[11:9] and `dma_chan[5:3]` from W11[8:6].
  - `dev_active[d]` comes from W12[15-d].
  - `oe0_cfg` comes from W12[10:8] and `oe1_cfg` from W12[7:5].
  - `cfg_mode` comes from W12[4].
  - `dma_map[3c+:3]` comes from W13[3c+:3].
- R7: With `cfg_mode`=1, all four memory outputs read 0.
- R8: With `cfg_mode`=0, the following read 0: I/O base, block size, IRQ level and active flag of devices 2 to 4; `oe1_cfg`; and `dma_map[14:3]`. Devices 0 and 1, `dma_chan`, `oe0_cfg` and `dma_map[2:0]` keep their values.
- R9: Every configuration output is 0 until `cfg_done` rises. `cfg_done` then stays high, and no further frame starts.
- R10: A reset in the middle of a load discards the partial load, and loading restarts from word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Command bits to the EEPROM |
| ee_do | input | 1 | Data bits from the EEPROM |
| cfg_done | output | 1 | All words loaded; outputs valid |
| mem_base0 | output | 16 | Device 0 memory base, address bits 23..8 |
| mem_base1 | output | 16 | Device 1 memory base, address bits 23..8 |
| mem_top0 | output | 16 | Device 0 memory upper limit, bits 23..8 |
| mem_top1 | output | 16 | Device 1 memory upper limit, bits 23..8 |
| io_base | output | 80 | Five 16-bit I/O bases, device d at [16d+:16] |
| io_size | output | 15 | Five 3-bit block sizes, device d at [3d+:3] |
| irq_lvl | output | 20 | Five 4-bit IRQ levels, device d at [4d+:4] |
| dma_chan | output | 6 | DMA channel of devices 0 and 1 |
| dev_active | output | 5 | Active flag per device |
| oe0_cfg | output | 3 | First output-enable configuration |
| oe1_cfg | output | 3 | Second output-enable configuration |
| cfg_mode | output | 1 | Loaded mode bit |
| dma_map | output | 15 | Five 3-bit DMA remap entries, channel c at [3c+:3] |

## Verification
The bench checks the masking in both modes using words whose masked bits are all ones. A design that applied the mode bit to the wrong fields, or applied it before word 12 arrived, would leave nonzero values in fields that should read 0. An EEPROM model checks every frame for the opcode, the address order, the 26-edge length and the serial clock period. An off-by-one in the dummy bit would shift every captured word by one place. A reset in the middle of a load checks that the address counter starts again at word 0 and does not resume. After done, the bench watches the link so that a loader that wraps around and reads again is caught.

// File: rtl/cfgld_pkg.sv
`timescale 1ns/1ps
package cfgld_pkg;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 6;
  localparam int N_WORDS    = 14;
  localparam int N_DEV      = 5;
  localparam int N_MAP      = 5;
  localparam int CMD_W      = 3 + ADDR_W;
  localparam int FRAME_BITS = CMD_W + 1 + DATA_W;
  localparam int IDX_W      = $clog2(N_WORDS);
  localparam logic [2:0] OP_READ = 3'b110;

  typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH, SH_GAP} sh_state_e;

  function automatic logic [CMD_W-1:0] read_cmd(input logic [ADDR_W-1:0] a);
    return {OP_READ, a};
  endfunction

  // 3-bit size of device d, packed from the top of the word downward
  function automatic logic [2:0] size_field(input logic [DATA_W-1:0] w, input int d);
    return w[15-3*d -: 3];
  endfunction

  // 4-bit IRQ level of device d (0..3), packed from the top downward
  function automatic logic [3:0] irq_field(input logic [DATA_W-1:0] w, input int d);
    return w[15-4*d -: 4];
  endfunction

  // 3-bit remap entry of channel c, packed from bit 0 upward
  function automatic logic [2:0] map_field(input logic [DATA_W-1:0] w, input int c);
    return w[3*c +: 3];
  endfunction
endpackage

// File: rtl/cfgld_shifter.sv
`timescale 1ns/1ps
module cfgld_shifter
  import cfgld_pkg::*;
#(
  parameter int SK_DIV = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sd_in,
  output logic              idle,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data,
  output logic              cs,
  output logic              sk,
  output logic              sd_out
);
  localparam int CNT_W = (SK_DIV > 1) ? $clog2(SK_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(SK_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] BIT_DATA0 = BIT_W'(CMD_W + 1);
  localparam logic [BIT_W-1:0] BIT_DUMMY = BIT_W'(CMD_W);

  sh_state_e         st;
  logic [CNT_W-1:0]  div_cnt;
  logic [BIT_W-1:0]  bitn;
  logic [CMD_W-1:0]  cmd_sh;
  logic [DATA_W-1:0] shreg;
  logic              tick;      // half-period boundary of the serial clock
  logic              sample_en; // this rising edge carries a data bit

  assign tick      = (div_cnt == CNT_LAST);
  assign sample_en = (st == SH_LOW) && tick && (bitn >= BIT_DATA0);
  assign idle      = (st == SH_IDLE);
  assign word_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SH_IDLE; div_cnt <= '0; bitn <= '0; cmd_sh <= '0; shreg <= '0;
      cs <= 1'b0; sk <= 1'b0; sd_out <= 1'b0; word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      case (st)
        SH_IDLE: begin
          div_cnt <= '0;
          if (start) begin
            cmd_sh <= read_cmd(addr);
            sd_out <= read_cmd(addr)[CMD_W-1];
            bitn   <= '0;
            cs     <= 1'b1;
            sk     <= 1'b0;
            st     <= SH_LOW;
          end
        end
        SH_LOW: begin
          if (tick) begin
            div_cnt <= '0;
            sk      <= 1'b1;
            st      <= SH_HIGH;
            if (sample_en) shreg <= {shreg[DATA_W-2:0], sd_in};
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        SH_HIGH: begin
          if (tick) begin
            div_cnt <= '0;
            sk      <= 1'b0;
            if (bitn == BIT_LAST) begin
              cs         <= 1'b0;
              sd_out     <= 1'b0;
              word_valid <= 1'b1;
              st         <= SH_GAP;
            end else begin
              bitn   <= bitn + 1'b1;
              cmd_sh <= cmd_sh << 1;
              sd_out <= cmd_sh[CMD_W-2];
              st     <= SH_LOW;
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: begin // SH_GAP: select held low for one half period
          if (tick) begin
            div_cnt <= '0;
            st      <= SH_IDLE;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  AST_SK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sk |-> cs);                                                      // R4
  AST_DI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && bitn >= BIT_DUMMY) |-> !sd_out);                          // R3
  AST_SK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == SH_LOW || st == SH_HIGH) && !tick) |=> $stable(sk));     // R5
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !idle) |-> cs);                                        // R2
endmodule

// File: rtl/cfgld_seq.sv
`timescale 1ns/1ps
module cfgld_seq
  import cfgld_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      eng_idle,
  input  logic                      word_valid,
  input  logic [DATA_W-1:0]         word_data,
  output logic                      start,
  output logic [ADDR_W-1:0]         addr,
  output logic [N_WORDS*DATA_W-1:0] words,
  output logic                      loaded
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_WORDS - 1);

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] wbuf [N_WORDS];
  logic              last_word; // the word being completed is the final one

  assign last_word = word_valid && (idx == IDX_LAST);
  assign start     = eng_idle && !loaded;
  assign addr      = ADDR_W'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      loaded <= 1'b0;
    end else if (word_valid && !loaded) begin
      if (last_word) loaded <= 1'b1;
      else           idx    <= idx + 1'b1;
    end
  end

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 wbuf[k] <= '0;
      else if (word_valid && !loaded && idx == IDX_W'(k)) wbuf[k] <= word_data;
    end
    assign words[k*DATA_W +: DATA_W] = wbuf[k];
  end

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !loaded && idx != IDX_LAST) |=> (idx == $past(idx) + 1'b1)); // R2
  AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded);                                                          // R9
  AST_NO_START_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |-> !start);                                                          // R9
endmodule

// File: rtl/cfgld_unpack.sv
`timescale 1ns/1ps
module cfgld_unpack
  import cfgld_pkg::*;
(
  input  logic [N_WORDS*DATA_W-1:0] words,
  input  logic                      loaded,
  output logic [15:0]               mem_base0,
  output logic [15:0]               mem_base1,
  output logic [15:0]               mem_top0,
  output logic [15:0]               mem_top1,
  output logic [N_DEV*16-1:0]       io_base,
  output logic [N_DEV*3-1:0]        io_size,
  output logic [N_DEV*4-1:0]        irq_lvl,
  output logic [5:0]                dma_chan,
  output logic [N_DEV-1:0]          dev_active,
  output logic [2:0]                oe0_cfg,
  output logic [2:0]                oe1_cfg,
  output logic                      mode,
  output logic [N_MAP*3-1:0]        dma_map
);
  logic [DATA_W-1:0] w [N_WORDS];
  for (genvar k = 0; k < N_WORDS; k++) begin : g_split
    assign w[k] = words[k*DATA_W +: DATA_W];
  end

  logic mem_en;  // memory words take effect only in mode 0
  logic wide_en; // devices 2..4 and extra channels take effect only in mode 1
  assign mode    = loaded && w[12][4];
  assign mem_en  = loaded && !mode;
  assign wide_en = loaded && mode;

  assign mem_base0 = mem_en ? w[0] : '0;
  assign mem_base1 = mem_en ? w[1] : '0;
  assign mem_top0  = mem_en ? w[2] : '0;
  assign mem_top1  = mem_en ? w[3] : '0;

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    logic en;
    if (d < 2) begin : g_base_dev
      assign en = loaded;
    end else begin : g_wide_dev
      assign en = wide_en;
    end
    assign io_base[16*d +: 16] = en ? w[4+d] : '0;
    assign io_size[3*d +: 3]   = en ? size_field(w[9], d) : '0;
    assign dev_active[d]       = en && w[12][15-d];
    if (d < 4) begin : g_irq_a
      assign irq_lvl[4*d +: 4] = en ? irq_field(w[10], d) : '0;
    end else begin : g_irq_b
      assign irq_lvl[4*d +: 4] = en ? w[11][15:12] : '0;
    end
  end

  for (genvar c = 0; c < N_MAP; c++) begin : g_map
    if (c == 0) begin : g_map0
      assign dma_map[3*c +: 3] = loaded ? map_field(w[13], c) : '0;
    end else begin : g_mapn
      assign dma_map[3*c +: 3] = wide_en ? map_field(w[13], c) : '0;
    end
  end

  assign dma_chan = loaded ? {w[11][8:6], w[11][11:9]} : '0;
  assign oe0_cfg  = loaded ? w[12][10:8] : '0;
  assign oe1_cfg  = wide_en ? w[12][7:5] : '0;

  logic unused_bits;
  assign unused_bits = ^{w[9][0], w[11][5:0], w[12][3:0], w[13][15]};
endmodule

// File: rtl/eeprom_cfg_loader.sv
`timescale 1ns/1ps
module eeprom_cfg_loader
  import cfgld_pkg::*;
#(
  parameter int SK_DIV = 4
)(
  input  logic        clk,
  input  logic        rst_n,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do,
  output logic        cfg_done,
  output logic [15:0] mem_base0,
  output logic [15:0] mem_base1,
  output logic [15:0] mem_top0,
  output logic [15:0] mem_top1,
  output logic [79:0] io_base,
  output logic [14:0] io_size,
  output logic [19:0] irq_lvl,
  output logic [5:0]  dma_chan,
  output logic [4:0]  dev_active,
  output logic [2:0]  oe0_cfg,
  output logic [2:0]  oe1_cfg,
  output logic        cfg_mode,
  output logic [14:0] dma_map
);
  logic                      eng_idle, word_valid, start;
  logic [DATA_W-1:0]         word_data;
  logic [ADDR_W-1:0]         addr;
  logic [N_WORDS*DATA_W-1:0] words;

  cfgld_shifter #(.SK_DIV(SK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .sd_in(ee_do),
    .idle(eng_idle), .word_valid(word_valid), .word_data(word_data),
    .cs(ee_cs), .sk(ee_sk), .sd_out(ee_di));

  cfgld_seq u_seq (
    .clk(clk), .rst_n(rst_n), .eng_idle(eng_idle), .word_valid(word_valid),
    .word_data(word_data), .start(start), .addr(addr), .words(words),
    .loaded(cfg_done));

  cfgld_unpack u_unpack (
    .words(words), .loaded(cfg_done),
    .mem_base0(mem_base0), .mem_base1(mem_base1),
    .mem_top0(mem_top0), .mem_top1(mem_top1),
    .io_base(io_base), .io_size(io_size), .irq_lvl(irq_lvl),
    .dma_chan(dma_chan), .dev_active(dev_active),
    .oe0_cfg(oe0_cfg), .oe1_cfg(oe1_cfg), .mode(cfg_mode), .dma_map(dma_map));

  AST_QUIET_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> ({mem_base0, mem_base1, mem_top0, mem_top1, io_base, io_size,
                    irq_lvl, dma_chan, dev_active, oe0_cfg, oe1_cfg, cfg_mode,
                    dma_map} == '0));                                   // R9
  AST_LINK_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> !ee_cs);                                               // R9
  AST_MODE1_MEM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && cfg_mode) |-> ({mem_base0, mem_base1, mem_top0, mem_top1} == '0)); // R7
  AST_MODE0_WIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && !cfg_mode) |-> (io_base[79:32] == '0 && oe1_cfg == '0 &&
                                 dma_map[14:3] == '0 && dev_active[4:2] == '0)); // R8
endmodule

// File: tb/eeprom_cfg_loader_bench.sv
`timescale 1ns/1ps
module eeprom_cfg_loader_bench;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ee_cs, ee_sk, ee_di, cfg_done, cfg_mode;
  logic ee_do = 1'b0;
  logic [15:0] mem_base0, mem_base1, mem_top0, mem_top1;
  logic [79:0] io_base;
  logic [14:0] io_size, dma_map;
  logic [19:0] irq_lvl;
  logic [5:0]  dma_chan;
  logic [4:0]  dev_active;
  logic [2:0]  oe0_cfg, oe1_cfg;

  always #2 clk = ~clk; // 250 MHz

  eeprom_cfg_loader #(.SK_DIV(DIV)) u_eeprom_cfg_loader (
    .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do), .cfg_done(cfg_done), .mem_base0(mem_base0),
    .mem_base1(mem_base1), .mem_top0(mem_top0), .mem_top1(mem_top1),
    .io_base(io_base), .io_size(io_size), .irq_lvl(irq_lvl),
    .dma_chan(dma_chan), .dev_active(dev_active), .oe0_cfg(oe0_cfg),
    .oe1_cfg(oe1_cfg), .cfg_mode(cfg_mode), .dma_map(dma_map));

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [15:0] rom [14];
  int exp_q [$];   // scoreboard: expected word addresses in order
  int edge_n = 0, frames = 0, t_e1 = 0;
  logic [8:0] cmd = '0;
  int cur_addr = 0;
  bit aborting = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // EEPROM model and monitor side of the scoreboard
  always @(posedge ee_cs) edge_n = 0;
  always @(posedge ee_sk) begin
    if (ee_cs) begin
      edge_n++;
      if (edge_n == 1) t_e1 = cyc;
      if (edge_n == 2) chk("R5 sk period", 128'(cyc - t_e1), 128'(2*DIV));
      if (edge_n <= 9) cmd = {cmd[7:0], ee_di};
      if (edge_n >= 10 && edge_n <= 26) chk("R3 di low after command", 128'(ee_di), 128'(0));
      if (edge_n == 9) begin
        chk("R2 opcode", 128'(cmd[8:6]), 128'(3'b110));
        cur_addr = int'(cmd[5:0]);
        if (exp_q.size() == 0) chk("R2 unexpected frame", 128'(1), 128'(0));
        else chk("R2 address order", 128'(cur_addr), 128'(exp_q.pop_front()));
        ee_do = 1'b0; // dummy bit
      end else if (edge_n >= 10 && edge_n <= 25) begin
        ee_do = rom[cur_addr % 14][15 - (edge_n - 10)];
      end
    end
  end
  always @(negedge ee_cs) begin
    if (!aborting) begin
      chk("R3 R4 edges per frame", 128'(edge_n), 128'(26));
      frames++;
    end
  end

  task automatic push_all();
    exp_q.delete();
    for (int a = 0; a < 14; a++) exp_q.push_back(a);
    frames = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (cfg_done) begin ok = 1; break; end
    end
    if (!ok) chk("R9 watchdog: done never rose", 128'(0), 128'(1));
  endtask

  task automatic check_outputs(input string tag);
    bit m;
    logic [79:0] eb; logic [14:0] es, em; logic [19:0] ei; logic [4:0] ea;
    m = rom[12][4];
    for (int d = 0; d < 5; d++) begin
      bit on = (d < 2) || m;
      eb[16*d +: 16] = on ? rom[4+d] : 16'h0;
      es[3*d +: 3]   = on ? 3'((rom[9] >> (13 - 3*d)) & 16'h7) : 3'h0;
      ei[4*d +: 4]   = on ? ((d < 4) ? 4'((rom[10] >> (12 - 4*d)) & 16'hF)
                                     : 4'(rom[11] >> 12)) : 4'h0;
      ea[d]          = on & rom[12][15-d];
      em[3*d +: 3]   = ((d == 0) || m) ? 3'((rom[13] >> (3*d)) & 16'h7) : 3'h0;
    end
    chk({tag, " R6 mode"}, 128'(cfg_mode), 128'(m));
    chk({tag, " R6 R7 memory"}, {mem_base0, mem_base1, mem_top0, mem_top1},
        m ? 128'(0) : 128'({rom[0], rom[1], rom[2], rom[3]}));
    chk({tag, " R6 R8 io base"}, 128'(io_base), 128'(eb));
    chk({tag, " R6 R8 io size"}, 128'(io_size), 128'(es));
    chk({tag, " R6 R8 irq"}, 128'(irq_lvl), 128'(ei));
    chk({tag, " R6 R8 active"}, 128'(dev_active), 128'(ea));
    chk({tag, " R6 dma chan"}, 128'(dma_chan), 128'({rom[11][8:6], rom[11][11:9]}));
    chk({tag, " R6 oe0"}, 128'(oe0_cfg), 128'(rom[12][10:8]));
    chk({tag, " R6 R8 oe1"}, 128'(oe1_cfg), m ? 128'(rom[12][7:5]) : 128'(0));
    chk({tag, " R6 R8 dma map"}, 128'(dma_map), 128'(em));
  endtask

  task automatic zero_outputs(input string req);
    chk(req, {mem_base0, mem_base1, mem_top0, mem_top1, io_base[63:0]}, 128'(0));
    chk(req, 128'({io_base[79:64], io_size, irq_lvl, dma_chan, dev_active,
                   oe0_cfg, oe1_cfg, cfg_mode, dma_map}), 128'(0));
  endtask

  task automatic run_load(input string tag);
    bit ok;
    push_all();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 link idle in reset", 128'({ee_cs, ee_sk, ee_di, cfg_done}), 128'(0));
    zero_outputs("R1 outputs zero in reset");
    rst_n = 1'b1;
    repeat (200) @(negedge clk);
    zero_outputs("R9 outputs zero mid-load");
    wait_done(ok);
    if (ok) begin
      check_outputs(tag);
      chk("R2 all addresses read", 128'(exp_q.size()), 128'(0));
      repeat (600) @(negedge clk);
      chk("R9 no frame after done", 128'(frames), 128'(14));
      chk("R9 done sticky", 128'(cfg_done), 128'(1));
    end
  endtask

  initial begin
    bit ok;
    // Pattern A: mode 1, mixed bits
    for (int i = 0; i < 14; i++) rom[i] = 16'hA5C3 ^ 16'(i * 16'h1357);
    rom[12][4] = 1'b1;
    run_load("A");
    // Pattern B: mode 0, everything else ones, so masked fields show
    for (int i = 0; i < 14; i++) rom[i] = 16'hFFFF;
    rom[12][4] = 1'b0;
    run_load("B");
    // Pattern C: mode 1 with all ones, memory words must vanish
    rom[12][4] = 1'b1;
    run_load("C");
    // R10: reset in the middle of a load, new contents, restart at 0
    for (int i = 0; i < 14; i++) rom[i] = 16'h3C96 + 16'(i * 16'h0111);
    rom[12][4] = 1'b0;
    push_all();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 20000 && frames < 3; i++) @(negedge clk);
    repeat (50) @(negedge clk);
    aborting = 1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 R1 link idle after abort", 128'({ee_cs, cfg_done}), 128'(0));
    push_all();
    rst_n = 1'b1;
    @(negedge clk);
    aborting = 0;
    wait_done(ok);
    if (ok) begin
      check_outputs("R10 restart");
      chk("R10 frames after restart", 128'(frames), 128'(14));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog R9 act=timeout exp=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule